// File: doc/BRIEF.md
# Bus Error Summary Priority Logger

This block takes the per-transaction error events reported by a set of data-slice status sources (two slices by default) and folds them into one sticky summary word of four flags. Each slice reports five raw event kinds on every data transaction. The block ranks the errors by significance and raises only the flag of the most significant error in that transaction.

The block also keeps one indicator bit per slice. These bits mark which slices reported the most significant error recorded so far. A new error that ranks strictly higher than the recorded one replaces the whole indicator set. An error of equal rank adds its slices to the set, and a lower-ranked error leaves the set unchanged. Software clears flags by writing ones to a clear mask. Once every flag is clear, the recorded rank and the indicators return to zero.

Top module: `errsum_logger`

## Requirements
- R1: After reset `sum_flags`, `slice_ind` and `top_level` are all zero.
- R2: Each slice has a 5-bit event field at `ev_bits[5*s +: 5]`, with bit 0 = corrected read ECC, bit 1 = corrected write ECC, bit 2 = uncorrectable ECC, bit 3 = data-valid/transmit check, bit 4 = transmit check. A corrected read ECC event ranks at level 2 and sets flag bit 0 (read data error).
- R3: A corrected write ECC event ranks at level 3 and sets flag bit 1 (write data error).
- R4: An uncorrectable ECC event ranks at level 4, the highest level, and sets flag bit 2 (uncorrectable data error).
- R5: A data-valid/transmit check event ranks as a corrected read (level 2, flag bit 0) when `ev_write`=0, and as a corrected write (level 3, flag bit 1) when `ev_write`=1.
- R6: A transmit check event ranks at level 1 and sets flag bit 3 only when no slice reports an ECC event (bits 0..2) in the same transaction. Otherwise it is ignored.
- R7: A transaction sets only the flag that matches its highest slice level, whether the errors come from one slice or from several.
- R8: `top_level` holds the highest level recorded since the flags were last all clear. A transaction ranked strictly above it replaces `slice_ind` with the slices at the transaction's level. A transaction of equal rank ORs those slices into `slice_ind`. A lower-ranked transaction leaves `slice_ind` and `top_level` unchanged.
- R9: Flags are sticky. With no clear, no flag falls, and a lower-ranked transaction still sets its own flag.
- R10: When `clr_valid`=1, flags whose `clr_mask` bit is 1 are cleared before any event in the same cycle is merged. If this leaves no flag set, `top_level` and `slice_ind` restart from zero.
- R11: All updates appear on the outputs one clock after the inputs are sampled, and nothing changes when `ev_valid`=0 and `clr_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | A data transaction's events are present this cycle |
| ev_write | input | 1 | 1 = the transaction is a write command, 0 = a read |
| ev_bits | input | 5*NS | Per-slice raw event bits, slice s at [5*s +: 5] |
| clr_valid | input | 1 | Apply the write-one-to-clear mask this cycle |
| clr_mask | input | 4 | Flags to clear |
| sum_flags | output | 4 | Summary flags: 0 read data, 1 write data, 2 uncorrectable, 3 transmit check |
| slice_ind | output | NS | Slices holding the highest-ranked recorded error |
| top_level | output | 3 | Recorded highest level: 0 none, 1 transmit check, 2 read, 3 write, 4 uncorrectable |

## Verification
The bench sweeps every pair of slice event patterns under both command directions, each from a cleared state. This exposes four kinds of fault: a design that ORs the flags together instead of ranking them, one that lets transmit check through beside an ECC error, and one that maps data-valid check to the wrong direction. The sweep also catches a design that marks a lower-ranked slice as an indicator. A long pseudo-random run then stacks transactions on top of recorded state and applies partial clears. In that run, a design that replaces indicators on an equal rank, or lets a lower rank change them, diverges from the reference. The same holds for a design that keeps the old rank after all flags are cleared, or that applies the clear after a same-cycle event.

// File: rtl/errsum_pkg.sv
package errsum_pkg;
  localparam int EV_W   = 5;
  localparam int FLAG_W = 4;
  localparam int LVL_W  = 3;

  // raw event bit positions inside one slice field
  localparam int EB_CRD  = 0;
  localparam int EB_CWR  = 1;
  localparam int EB_UNC  = 2;
  localparam int EB_DVTC = 3;
  localparam int EB_TC   = 4;

  // significance levels
  localparam logic [LVL_W-1:0] LV_NONE = 3'd0;
  localparam logic [LVL_W-1:0] LV_TC   = 3'd1;
  localparam logic [LVL_W-1:0] LV_CRD  = 3'd2;
  localparam logic [LVL_W-1:0] LV_CWR  = 3'd3;
  localparam logic [LVL_W-1:0] LV_UNC  = 3'd4;

  // rank of one slice given the command direction and whether any slice saw ECC
  function automatic logic [LVL_W-1:0] slice_level(input logic [EV_W-1:0] ev,
                                                   input logic wr,
                                                   input logic ecc_any);
    logic [LVL_W-1:0] l;
    l = LV_NONE;
    if (ev[EB_TC] && !ecc_any)                   l = LV_TC;
    if (ev[EB_CRD] || (ev[EB_DVTC] && !wr))      l = LV_CRD;
    if (ev[EB_CWR] || (ev[EB_DVTC] &&  wr))      l = LV_CWR;
    if (ev[EB_UNC])                              l = LV_UNC;
    return l;
  endfunction

  // summary flag raised by a level
  function automatic logic [FLAG_W-1:0] level_flag(input logic [LVL_W-1:0] l);
    logic [FLAG_W-1:0] f;
    f = '0;
    case (l)
      LV_TC:   f[3] = 1'b1;
      LV_CRD:  f[0] = 1'b1;
      LV_CWR:  f[1] = 1'b1;
      LV_UNC:  f[2] = 1'b1;
      default: f = '0;
    endcase
    return f;
  endfunction
endpackage

// File: rtl/errsum_classify.sv
module errsum_classify
  import errsum_pkg::*;
#(
  parameter int NS = 2
) (
  input  logic [NS*EV_W-1:0]  ev_bits,
  input  logic                ev_write,
  output logic [NS*LVL_W-1:0] slice_lvls,
  output logic                ecc_any
);
  logic [NS-1:0] ecc_per;

  for (genvar s = 0; s < NS; s++) begin : g_slice
    logic [EV_W-1:0] f;
    assign f          = ev_bits[s*EV_W +: EV_W];
    assign ecc_per[s] = f[EB_CRD] | f[EB_CWR] | f[EB_UNC];
    assign slice_lvls[s*LVL_W +: LVL_W] = slice_level(f, ev_write, ecc_any);
  end

  assign ecc_any = |ecc_per;
endmodule

// File: rtl/errsum_rank.sv
module errsum_rank
  import errsum_pkg::*;
#(
  parameter int NS = 2
) (
  input  logic [NS*LVL_W-1:0] slice_lvls,
  output logic [LVL_W-1:0]    txn_lvl,
  output logic [NS-1:0]       txn_hit
);
  always_comb begin
    txn_lvl = LV_NONE;
    for (int s = 0; s < NS; s++) begin
      if (slice_lvls[s*LVL_W +: LVL_W] > txn_lvl) txn_lvl = slice_lvls[s*LVL_W +: LVL_W];
    end
  end

  for (genvar s = 0; s < NS; s++) begin : g_hit
    assign txn_hit[s] = (txn_lvl != LV_NONE) && (slice_lvls[s*LVL_W +: LVL_W] == txn_lvl);
  end
endmodule

// File: rtl/errsum_logger.sv
module errsum_logger
  import errsum_pkg::*;
#(
  parameter int NS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ev_valid,
  input  logic                 ev_write,
  input  logic [NS*5-1:0]      ev_bits,
  input  logic                 clr_valid,
  input  logic [3:0]           clr_mask,
  output logic [3:0]           sum_flags,
  output logic [NS-1:0]        slice_ind,
  output logic [2:0]           top_level
);
  logic [NS*LVL_W-1:0] slice_lvls;
  logic                ecc_any;
  logic [LVL_W-1:0]    txn_lvl;
  logic [NS-1:0]       txn_hit;

  // named internal events
  logic [FLAG_W-1:0] flags_kept;
  logic              all_clear;
  logic [LVL_W-1:0]  base_lvl;
  logic [NS-1:0]     base_ind;
  logic              txn_err;
  logic              raise;
  logic              tie;

  logic [FLAG_W-1:0] flags_n;
  logic [NS-1:0]     ind_n;
  logic [LVL_W-1:0]  lvl_n;

  errsum_classify #(.NS(NS)) u_cls (
    .ev_bits    (ev_bits),
    .ev_write   (ev_write),
    .slice_lvls (slice_lvls),
    .ecc_any    (ecc_any)
  );

  errsum_rank #(.NS(NS)) u_rank (
    .slice_lvls (slice_lvls),
    .txn_lvl    (txn_lvl),
    .txn_hit    (txn_hit)
  );

  assign flags_kept = sum_flags & ~(clr_valid ? clr_mask : '0);
  assign all_clear  = (flags_kept == '0);
  assign base_lvl   = all_clear ? LV_NONE : top_level;
  assign base_ind   = all_clear ? '0 : slice_ind;
  assign txn_err    = ev_valid && (txn_lvl != LV_NONE);
  assign raise      = txn_err && (txn_lvl >  base_lvl);
  assign tie        = txn_err && (txn_lvl == base_lvl);

  always_comb begin
    flags_n = flags_kept | (txn_err ? level_flag(txn_lvl) : '0);
    lvl_n   = raise ? txn_lvl : base_lvl;
    if (raise)    ind_n = txn_hit;
    else if (tie) ind_n = base_ind | txn_hit;
    else          ind_n = base_ind;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_flags <= '0;
      slice_ind <= '0;
      top_level <= LV_NONE;
    end else begin
      sum_flags <= flags_n;
      slice_ind <= ind_n;
      top_level <= lvl_n;
    end
  end
endmodule

// File: rtl/errsum_chk.sv
module errsum_chk #(
  parameter int NS = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ev_valid,
  input logic            ev_write,
  input logic [NS*5-1:0] ev_bits,
  input logic            clr_valid,
  input logic [3:0]      clr_mask,
  input logic [3:0]      sum_flags,
  input logic [NS-1:0]   slice_ind,
  input logic [2:0]      top_level
);
  logic [NS-1:0] unc_s, ecc_s;
  for (genvar s = 0; s < NS; s++) begin : g_s
    assign unc_s[s] = ev_bits[5*s+2];
    assign ecc_s[s] = |ev_bits[5*s +: 3];
  end

  p_unc_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && |unc_s) |=> sum_flags[2]);

  p_tc_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && |ecc_s && !clr_valid && !sum_flags[3]) |=> !sum_flags[3]);

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_valid |=> ((sum_flags & $past(sum_flags)) == $past(sum_flags)));

  p_level_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_valid |=> (top_level >= $past(top_level)));

  p_ind_present_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (top_level != 3'd0) == (slice_ind != '0));

  p_clear_all_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_valid && clr_mask == 4'hF && !ev_valid) |=> (sum_flags == 4'h0 && top_level == 3'd0));

  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_valid && !clr_valid) |=> ($stable(sum_flags) && $stable(slice_ind) && $stable(top_level)));
endmodule

bind errsum_logger errsum_chk #(.NS(NS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ev_valid  (ev_valid),
  .ev_write  (ev_write),
  .ev_bits   (ev_bits),
  .clr_valid (clr_valid),
  .clr_mask  (clr_mask),
  .sum_flags (sum_flags),
  .slice_ind (slice_ind),
  .top_level (top_level)
);

// File: tb/sim_errsum_logger.sv
`timescale 1ns/1ps
module sim_errsum_logger;
  localparam int NS = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ev_valid = 1'b0, ev_write = 1'b0, clr_valid = 1'b0;
  logic [9:0]    ev_bits = '0;
  logic [3:0]    clr_mask = '0;
  logic [3:0]    sum_flags;
  logic [1:0]    slice_ind;
  logic [2:0]    top_level;

  int checks = 0, failures = 0, cyc = 0;
  logic [3:0] m_flags = '0;
  logic [1:0] m_ind = '0;
  int         m_lvl = 0;

  always #5 clk = ~clk;

  errsum_logger #(.NS(NS)) u0 (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_write(ev_write),
    .ev_bits(ev_bits), .clr_valid(clr_valid), .clr_mask(clr_mask),
    .sum_flags(sum_flags), .slice_ind(slice_ind), .top_level(top_level)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks = checks + 1;
    if (got != exp) begin
      failures = failures + 1;
      $display("FAIL %s got=%0h exp=%0h at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  // significance of one slice: 4 unc, 3 write-side, 2 read-side, 1 lone transmit check
  function automatic int rank(input logic [4:0] e, input logic w, input logic ecc);
    if (e[2]) return 4;
    if (e[1] || (e[3] && w)) return 3;
    if (e[0] || (e[3] && !w)) return 2;
    if (e[4] && !ecc) return 1;
    return 0;
  endfunction

  function automatic logic [3:0] flag_of(input int l);
    logic [3:0] t [5] = '{4'h0, 4'h8, 4'h1, 4'h2, 4'h4};
    return t[l];
  endfunction

  task automatic step(input logic ev, input logic w, input logic [9:0] b,
                      input logic cv, input logic [3:0] m);
    int r0, r1, tl;
    logic ecc;
    @(negedge clk);
    ev_valid = ev; ev_write = w; ev_bits = b; clr_valid = cv; clr_mask = m;
    // reference update: clear first, then merge the event
    if (cv) m_flags = m_flags & ~m;
    if (m_flags == 4'h0) begin m_lvl = 0; m_ind = 2'b00; end
    ecc = (b[2:0] != 0) || (b[7:5] != 0);
    r0 = rank(b[4:0], w, ecc);
    r1 = rank(b[9:5], w, ecc);
    tl = (r0 > r1) ? r0 : r1;
    if (ev && tl != 0) begin
      m_flags = m_flags | flag_of(tl);
      if (tl > m_lvl) begin
        m_lvl = tl;
        m_ind = {r1 == tl, r0 == tl};
      end else if (tl == m_lvl) begin
        m_ind = m_ind | {r1 == tl, r0 == tl};
      end
    end
    @(posedge clk);
    #1;
    ev_valid = 1'b0; clr_valid = 1'b0;
  endtask

  task automatic cmp_all(input string tf, input string ti, input string tl);
    chk(tf, sum_flags, m_flags);
    chk(ti, slice_ind, m_ind);
    chk(tl, top_level, m_lvl);
  endtask

  initial begin
    logic [31:0] lf;
    repeat (3) @(posedge clk);
    #1;
    cmp_all("R1 flags", "R1 ind", "R1 level");
    @(negedge clk);
    rst_n = 1'b1;

    // directed mapping cases
    step(1, 0, 10'b00000_00001, 0, 0); chk("R2 crd flag", sum_flags, 4'h1); chk("R2 level", top_level, 2);
    step(0, 0, 0, 1, 4'hF);
    step(1, 1, 10'b00010_00000, 0, 0); chk("R3 cwr flag", sum_flags, 4'h2); chk("R3 level", top_level, 3);
    chk("R3 ind slice1", slice_ind, 2'b10);
    step(0, 0, 0, 1, 4'hF);
    step(1, 0, 10'b00100_00000, 0, 0); chk("R4 unc flag", sum_flags, 4'h4); chk("R4 level", top_level, 4);
    step(0, 0, 0, 1, 4'hF);
    step(1, 0, 10'b00000_01000, 0, 0); chk("R5 dvtc read", sum_flags, 4'h1);
    step(0, 0, 0, 1, 4'hF);
    step(1, 1, 10'b00000_01000, 0, 0); chk("R5 dvtc write", sum_flags, 4'h2);
    step(0, 0, 0, 1, 4'hF);
    step(1, 0, 10'b00000_10000, 0, 0); chk("R6 lone tc", sum_flags, 4'h8); chk("R6 level", top_level, 1);
    step(0, 0, 0, 1, 4'hF);
    step(1, 0, 10'b00001_10000, 0, 0); chk("R6 tc masked", sum_flags, 4'h1);
    chk("R6 tc masked ind", slice_ind, 2'b10);
    step(0, 0, 0, 1, 4'hF);
    step(1, 0, 10'b00001_00100, 0, 0); chk("R7 unc+crd", sum_flags, 4'h4); chk("R8 only slice0", slice_ind, 2'b01);
    step(1, 0, 10'b00100_00000, 0, 0); chk("R8 tie adds slice1", slice_ind, 2'b11);
    step(1, 0, 10'b00000_00001, 0, 0); chk("R9 lower sets flag", sum_flags, 4'h5);
    chk("R8 lower keeps ind", slice_ind, 2'b11);
    step(0, 0, 0, 1, 4'h4); chk("R10 partial keeps level", top_level, 4);
    step(1, 0, 10'b00000_00010, 1, 4'h1); chk("R10 clear then event", sum_flags, 4'h2);
    chk("R10 level restarted", top_level, 3); chk("R10 ind restarted", slice_ind, 2'b01);
    step(0, 0, 10'b00100_00100, 0, 0); chk("R11 no valid no change", sum_flags, 4'h2);
    cmp_all("R11 flags", "R11 ind", "R11 level");

    // exhaustive sweep from a cleared state
    for (int a = 0; a < 32; a++)
      for (int b = 0; b < 32; b++)
        for (int w = 0; w < 2; w++) begin
          step(0, 0, 0, 1, 4'hF);
          chk("R10 cleared level", top_level, 0);
          step(1, w[0], {b[4:0], a[4:0]}, 0, 0);
          cmp_all("R7 flags", "R8 ind", "R8 level");
        end

    // stacked pseudo-random sequence
    lf = 32'h1D2C3B4A;
    for (int i = 0; i < 4000; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      step(lf[28] | lf[29], lf[30], lf[9:0] & lf[19:10], lf[23:20] == 0, lf[27:24]);
      cmp_all("R9 flags", "R8 ind", "R10 level");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule